// File: doc/BRIEF.md
# Disk Write Fault Latch Controller

This block watches the write-path health signals of a disk drive and latches the first write fault it detects. There are five fault kinds. Two are nondestructive: a write while the heads are not settled on cylinder, and a read gate raised during a write. Three are destructive: a write with no alternating write current, more than one head selected, and DC write current with no write in progress. Once a fault is latched, every later fault condition is locked out until the fault is cleared.

Each fault kind has its own active-low indicator. The controller also drives a combined write-fault flag and one summary line per class. A nondestructive fault turns on the drive-fault lamp and sets status bit 4. A destructive fault raises a one-cycle request to unload the heads. Nondestructive faults can be cleared by power-on sequence start, by the RUN switch or by a clear-fault command. Destructive faults can be cleared only by power-on sequence start or RUN.

All six sense inputs pass through a two-flop synchronizer. The missing-AC-current check fires only after the condition has lasted a programmable number of cycles.

Top module: `wfault_latch_ctrl`

## Requirements
- R1: After reset all outputs are idle: every `flt_n` bit is 1, `wr_fault_n`, `nd_fault_n`, `d_fault_n` and `lamp_n` are 1, and `status4` and `unload_req` are 0. Sense inputs pass through two synchronizer flops. A fault condition applied just after a clock edge appears at the outputs after the third following edge, and not after the second.
- R2: Off-cylinder write fault, `flt_n[0]`: `wr_mode` is 1, `on_cyl` is 0 and no fault is latched.
- R3: Read-during-write fault, `flt_n[1]`: `wr_mode` is 1, `rd_gate` is 1 and no fault is latched.
- R4: Missing-AC fault, `flt_n[2]`: `wr_mode` is 1 and `ac_sense` is 0 for AC_LIMIT consecutive synchronized cycles, with no fault latched. With input applied after edge 0, the fault appears after edge 3+AC_LIMIT and not after edge 2+AC_LIMIT.
- R5: Multi-head fault, `flt_n[3]`: `mh_sense` is 1 and no fault is latched. The value of `wr_mode` does not matter.
- R6: DC-without-write fault, `flt_n[4]`: `dc_sense` is 1 while `wr_mode` is 0 and no fault is latched. If `dc_sense` is 1 during a write, this fault is not raised.
- R7: At most one `flt_n` bit is low at any time. `wr_fault_n` is low whenever any fault is latched. While a fault is held, other fault conditions have no effect on the outputs.
- R8: While a nondestructive fault (bit 0 or 1) is latched, `nd_fault_n` is 0, `lamp_n` is 0, `status4` is 1 and `d_fault_n` is 1.
- R9: While a destructive fault (bit 2, 3 or 4) is latched, `d_fault_n` is 0. `unload_req` is 1 for exactly the single cycle after the edge that latches the fault.
- R10: A nondestructive fault clears on the edge where `pwr_seq_start`, `run_sw` or `clr_cmd` is 1.
- R11: A destructive fault clears only on an edge where `pwr_seq_start` or `run_sw` is 1. `clr_cmd` leaves it latched.
- R12: When several conditions are true in the same cycle, only the highest-ranked one latches. The ranking, highest first, is multi-head, missing-AC, DC-without-write, off-cylinder, read-during-write.
- R13: In any cycle where a clear input is 1, no fault can latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | Write mode active |
| on_cyl | input | 1 | Heads settled on cylinder |
| rd_gate | input | 1 | Read gate active |
| ac_sense | input | 1 | Alternating write current present |
| mh_sense | input | 1 | More than one head selected |
| dc_sense | input | 1 | DC write current present |
| pwr_seq_start | input | 1 | Power-on sequence start, clears both classes |
| run_sw | input | 1 | RUN switch set, clears both classes |
| clr_cmd | input | 1 | Clear-fault command, clears nondestructive class only |
| flt_n | output | 5 | Per-fault indicators, active low |
| wr_fault_n | output | 1 | Combined write-fault flag, active low |
| nd_fault_n | output | 1 | Nondestructive summary, active low |
| d_fault_n | output | 1 | Destructive summary, active low |
| lamp_n | output | 1 | Drive-fault lamp, active low |
| status4 | output | 1 | Status bit 4 |
| unload_req | output | 1 | One-cycle head-unload request |

## Verification
A corrupted latch register is visible at once. The next cycle shows either two `flt_n` bits low together, or a summary line that disagrees with the indicator. If the lockout is broken, a second indicator drops three edges after a second condition is applied on top of a held fault. If the missing-AC counter is off by one, the fault moves by exactly one cycle relative to the 3+AC_LIMIT boundary. A wrong clear mapping shows up on the very next edge, when the destructive indicator either stays low or wrongly clears under `clr_cmd`.

// File: rtl/wfl_pkg.sv
package wfl_pkg;
    localparam int NUM_FAULTS = 5;
    localparam int SENSE_W    = 6;

    // fault indicator bit positions
    localparam int FI_NCYL  = 0;
    localparam int FI_RW    = 1;
    localparam int FI_NOAC  = 2;
    localparam int FI_MHEAD = 3;
    localparam int FI_DCNW  = 4;

    // synchronized sense vector bit positions
    localparam int SI_WR  = 0;
    localparam int SI_CYL = 1;
    localparam int SI_RG  = 2;
    localparam int SI_AC  = 3;
    localparam int SI_MH  = 4;
    localparam int SI_DC  = 5;

    localparam logic [NUM_FAULTS-1:0] DESTR_MASK =
        (NUM_FAULTS'(1) << FI_NOAC) | (NUM_FAULTS'(1) << FI_MHEAD) | (NUM_FAULTS'(1) << FI_DCNW);

    // priority rank to fault index, rank 0 highest
    localparam int RANK2IDX [NUM_FAULTS] = '{FI_MHEAD, FI_NOAC, FI_DCNW, FI_NCYL, FI_RW};

    typedef struct packed {
        logic [NUM_FAULTS-1:0] lat;
        logic                  unload;
    } wfl_state_t;
endpackage

// File: rtl/wfl_sync.sv
module wfl_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wfl_ac_timer.sv
module wfl_ac_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!arm)            cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = cnt_q;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = arm && (cnt_q == LIM);
endmodule

// File: rtl/wfl_prio.sv
module wfl_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wfault_latch_ctrl.sv
module wfault_latch_ctrl
    import wfl_pkg::*;
#(
    parameter int AC_LIMIT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_mode,
    input  logic                  on_cyl,
    input  logic                  rd_gate,
    input  logic                  ac_sense,
    input  logic                  mh_sense,
    input  logic                  dc_sense,
    input  logic                  pwr_seq_start,
    input  logic                  run_sw,
    input  logic                  clr_cmd,
    output logic [NUM_FAULTS-1:0] flt_n,
    output logic                  wr_fault_n,
    output logic                  nd_fault_n,
    output logic                  d_fault_n,
    output logic                  lamp_n,
    output logic                  status4,
    output logic                  unload_req
);
    logic [SENSE_W-1:0]    sense_raw, sense_s;
    logic                  ac_expired;
    logic [NUM_FAULTS-1:0] cond;
    logic [NUM_FAULTS-1:0] rank_req, rank_gnt;
    logic [NUM_FAULTS-1:0] pick;
    wfl_state_t            st_d, st_q;

    always_comb begin
        sense_raw         = '0;
        sense_raw[SI_WR]  = wr_mode;
        sense_raw[SI_CYL] = on_cyl;
        sense_raw[SI_RG]  = rd_gate;
        sense_raw[SI_AC]  = ac_sense;
        sense_raw[SI_MH]  = mh_sense;
        sense_raw[SI_DC]  = dc_sense;
    end

    wfl_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sense_raw),
        .dout (sense_s)
    );

    wfl_ac_timer #(.LIMIT(AC_LIMIT)) u_actmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (sense_s[SI_WR] && !sense_s[SI_AC]),
        .expired(ac_expired)
    );

    always_comb begin
        cond           = '0;
        cond[FI_NCYL]  = sense_s[SI_WR] && !sense_s[SI_CYL];
        cond[FI_RW]    = sense_s[SI_WR] && sense_s[SI_RG];
        cond[FI_NOAC]  = ac_expired;
        cond[FI_MHEAD] = sense_s[SI_MH];
        cond[FI_DCNW]  = sense_s[SI_DC] && !sense_s[SI_WR];
        for (int r = 0; r < NUM_FAULTS; r++) begin
            rank_req[r] = cond[RANK2IDX[r]];
        end
    end

    wfl_prio #(.N(NUM_FAULTS)) u_prio (
        .req(rank_req),
        .gnt(rank_gnt)
    );

    always_comb begin
        pick = '0;
        for (int r = 0; r < NUM_FAULTS; r++) begin
            pick[RANK2IDX[r]] = rank_gnt[r];
        end
    end

    always_comb begin
        logic any_clr;
        st_d        = st_q;
        st_d.unload = 1'b0;
        any_clr     = pwr_seq_start || run_sw || clr_cmd;
        if (pwr_seq_start || run_sw || clr_cmd) st_d.lat = st_d.lat & DESTR_MASK;
        if (pwr_seq_start || run_sw)            st_d.lat = st_d.lat & ~DESTR_MASK;
        if (st_q.lat == '0 && !any_clr) begin
            st_d.lat    = pick;
            st_d.unload = |(pick & DESTR_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_n      = ~st_q.lat;
    assign wr_fault_n = ~|st_q.lat;
    assign nd_fault_n = ~|(st_q.lat & ~DESTR_MASK);
    assign d_fault_n  = ~|(st_q.lat & DESTR_MASK);
    assign lamp_n     = nd_fault_n;
    assign status4    = ~nd_fault_n;
    assign unload_req = st_q.unload;
endmodule

// File: rtl/wfl_checker.sv
module wfl_checker
    import wfl_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_seq_start,
    input logic                  run_sw,
    input logic                  clr_cmd,
    input logic [NUM_FAULTS-1:0] flt_n,
    input logic                  wr_fault_n,
    input logic                  nd_fault_n,
    input logic                  d_fault_n,
    input logic                  lamp_n,
    input logic                  status4,
    input logic                  unload_req
);
    assert_single_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~flt_n));

    assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fault_n && !pwr_seq_start && !run_sw && !clr_cmd) |=> $stable(flt_n));

    assert_nd_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nd_fault_n |-> (!lamp_n && status4 && d_fault_n));

    assert_unload_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unload_req |=> !unload_req);

    assert_unload_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unload_req |-> (!d_fault_n && $past(d_fault_n)));

    assert_sys_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_seq_start || run_sw) |=> wr_fault_n);

    assert_destr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_fault_n && !pwr_seq_start && !run_sw) |=> !d_fault_n);
endmodule

bind wfault_latch_ctrl wfl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_seq_start(pwr_seq_start),
    .run_sw       (run_sw),
    .clr_cmd      (clr_cmd),
    .flt_n        (flt_n),
    .wr_fault_n   (wr_fault_n),
    .nd_fault_n   (nd_fault_n),
    .d_fault_n    (d_fault_n),
    .lamp_n       (lamp_n),
    .status4      (status4),
    .unload_req   (unload_req)
);

// File: tb/tb_wfault_latch_ctrl.sv
module tb_wfault_latch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ACL        = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_mode, on_cyl, rd_gate, ac_sense, mh_sense, dc_sense;
    logic       pwr_seq_start, run_sw, clr_cmd;
    logic [4:0] flt_n;
    logic       wr_fault_n, nd_fault_n, d_fault_n, lamp_n, status4, unload_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [10:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wfault_latch_ctrl #(.AC_LIMIT(ACL)) dut (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .on_cyl(on_cyl),
        .rd_gate(rd_gate), .ac_sense(ac_sense), .mh_sense(mh_sense),
        .dc_sense(dc_sense), .pwr_seq_start(pwr_seq_start), .run_sw(run_sw),
        .clr_cmd(clr_cmd), .flt_n(flt_n), .wr_fault_n(wr_fault_n),
        .nd_fault_n(nd_fault_n), .d_fault_n(d_fault_n), .lamp_n(lamp_n),
        .status4(status4), .unload_req(unload_req)
    );

    // expected port vector: {flt_n, wr_fault_n, nd_fault_n, d_fault_n, lamp_n, status4, unload_req}
    function automatic logic [10:0] expv(int idx, logic u);
        logic [4:0] f;
        logic nd, de;
        f  = 5'h1F;
        if (idx >= 0) f[idx] = 1'b0;
        nd = (idx == 0) || (idx == 1);
        de = (idx >= 2);
        return {f, (idx < 0), !nd, !de, !nd, nd, u};
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(int idx, logic u, string tag);
        exp_t e;
        e.v   = expv(idx, u);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic quiet();
        wr_mode = 1'b0; on_cyl = 1'b1; rd_gate = 1'b0;
        ac_sense = 1'b1; mh_sense = 1'b0; dc_sense = 1'b0;
    endtask

    task automatic pulse_clear(int which);
        if (which == 0) pwr_seq_start = 1'b1;
        else if (which == 1) run_sw = 1'b1;
        else clr_cmd = 1'b1;
        step(1);
        pwr_seq_start = 1'b0; run_sw = 1'b0; clr_cmd = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic [10:0] act;
                e   = q.pop_front();
                act = {flt_n, wr_fault_n, nd_fault_n, d_fault_n, lamp_n, status4, unload_req};
                total++;
                if (act !== e.v) begin
                    bad++;
                    $display("FAIL %s: actual=%b expected=%b", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        quiet();
        pwr_seq_start = 1'b0; run_sw = 1'b0; clr_cmd = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out(-1, 1'b0, "R1 reset idle");

        // R2 off-cylinder write, R1 sync latency
        wr_mode = 1'b1; on_cyl = 1'b0;
        step(2);
        expect_out(-1, 1'b0, "R1 not yet after two edges");
        step(1);
        expect_out(0, 1'b0, "R2 off-cylinder latched R8");
        // R7 lockout: read gate now also active
        rd_gate = 1'b1;
        step(4);
        expect_out(0, 1'b0, "R7 second condition ignored");
        quiet();
        step(3);
        pulse_clear(2);
        expect_out(-1, 1'b0, "R10 clear command clears nondestructive");

        // R3 read during write
        wr_mode = 1'b1; rd_gate = 1'b1;
        step(3);
        expect_out(1, 1'b0, "R3 read during write");
        quiet();
        step(3);
        pulse_clear(1);
        expect_out(-1, 1'b0, "R10 run clears nondestructive");

        // R4 missing AC current with window
        wr_mode = 1'b1; ac_sense = 1'b0;
        step(2 + ACL);
        expect_out(-1, 1'b0, "R4 not before limit");
        step(1);
        expect_out(2, 1'b1, "R4 missing AC latched R9 unload");
        step(1);
        expect_out(2, 1'b0, "R9 unload single cycle");
        quiet();
        step(3);
        pulse_clear(2);
        step(2);
        expect_out(2, 1'b0, "R11 clear command ignored by destructive");
        pulse_clear(0);
        expect_out(-1, 1'b0, "R11 power start clears destructive");

        // R5 multi-head without write
        mh_sense = 1'b1;
        step(3);
        expect_out(3, 1'b1, "R5 multi-head latched");
        quiet();
        step(3);
        pulse_clear(1);
        expect_out(-1, 1'b0, "R11 run clears destructive");

        // R6 DC without write
        dc_sense = 1'b1;
        step(3);
        expect_out(4, 1'b1, "R6 DC without write");
        quiet();
        step(3);
        pulse_clear(0);
        // R6 DC during write is not a fault
        wr_mode = 1'b1; dc_sense = 1'b1;
        step(4);
        expect_out(-1, 1'b0, "R6 DC during write no fault");
        quiet();
        step(3);

        // R12 priority: multi-head beats off-cylinder
        wr_mode = 1'b1; on_cyl = 1'b0; mh_sense = 1'b1;
        step(3);
        expect_out(3, 1'b1, "R12 multi-head over off-cylinder");
        quiet();
        step(3);
        pulse_clear(1);
        // R12 priority: off-cylinder beats read-during-write
        wr_mode = 1'b1; on_cyl = 1'b0; rd_gate = 1'b1;
        step(3);
        expect_out(0, 1'b0, "R12 off-cylinder over read-during-write");
        quiet();
        step(3);
        pulse_clear(0);

        // R13 held clear blocks setting
        pwr_seq_start = 1'b1;
        wr_mode = 1'b1; on_cyl = 1'b0;
        step(5);
        expect_out(-1, 1'b0, "R13 no latch while clear held");
        quiet();
        step(3);
        pwr_seq_start = 1'b0;
        step(1);
        expect_out(-1, 1'b0, "R13 idle after release");

        step(3);
        wait (q.size() == 0);
        step(1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule